// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Change Interrupt

This block is an 8-bit general-purpose I/O port. A host reaches it through a small register interface. The host programs the direction of each pin and the level that each output pin drives. It reads back the real level on all eight pins, and it chooses which input pins may raise an interrupt. The block drives a tri-state enable and an output level for every pin. It passes the pad inputs through a two-stage synchroniser and compares each synchronised sample with the one before it. When an enabled input pin changes, the block sets a sticky pending flag, which appears on an active-high level interrupt output.

A mode input lets the upper four pins act as modem-control lines. In that mode, the per-pin enables for those four pins are ignored. A single external enable input gates their change interrupts instead. The lower four pins keep their own enables in both modes. The pending flag clears when the host writes the direction register or reads the pin-level register.

Top module: `gpio_port`

## Requirements
- R1: Register address 0 holds the direction. When bit n is 1, pin n is an output (`pin_oe[n]`=1). When bit n is 0, pin n is an input. The new value shows on `pin_oe` in the cycle after the write.
- R2: Reading address 1 returns the synchronised level of all eight pins, whatever their direction. A pad change appears in this read data two clock edges later.
- R3: Writing address 1 sets `pin_out` in the next cycle. A bit written for an input pin is still stored, and it is driven once that pin becomes an output.
- R4: Address 2 holds the per-pin interrupt enables. The pending flag, seen on `irq` one edge after the synchronised change, is set only by a change on a pin that is both an input and enabled. A change on a disabled pin or on an output pin leaves `irq` low.
- R5: Any write to address 0 clears a pending interrupt, so `irq` is low in the next cycle, unless a new change is detected in that same cycle.
- R6: Reading address 1 also clears the pending flag. If neither clear happens, `irq` stays high once set.
- R7: When `modem_mode` is 1, enable bits 7 to 4 have no effect. Changes on input pins 7 to 4 then raise an interrupt only while `modem_irq_en` is 1. Pins 3 to 0 keep using their own enable bits.
- R8: After reset, direction, output data and enables are all zero, every pin is an input, and `irq` is low.
- R9: `rdata` is valid combinationally in the cycle that `rd_en` is high. Address 0 returns the direction, address 2 returns the enables, and address 3 returns zero. `rdata` is zero while `rd_en` is low.
- R10: If a change is detected in the same cycle as a clear, the change wins and `irq` stays high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, same cycle as `rd_en` |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Levels driven on output pins |
| pin_oe | output | 8 | Per-pin output enable |
| modem_mode | input | 1 | Upper four pins act as modem-control lines |
| modem_irq_en | input | 1 | Shared interrupt enable for pins 7 to 4 in modem mode |
| irq | output | 1 | Level interrupt, high while pending |

## Verification
A change detection can land in the same cycle as a clear of the pending flag, either through a direction write or through a pin-level read. The bench provokes this directly. It toggles an enabled input pin and, two edges later, issues the direction write. It does the same with a pin-level read. It then requires `irq` to remain high, because the new event must not be lost. Random traffic mixes register accesses with pad changes, so the same collisions also occur at random. A cycle-level reference model in the bench judges every cycle's `irq`, `pin_oe`, `pin_out` and read data.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic         wr_en,
  input  logic         rd_en,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic         modem_mode,
  input  logic         modem_irq_en,
  output logic         irq
);
  localparam int H = W / 2;

  logic [W-1:0] dir_q, dat_q, ien_q;
  logic [W-1:0] sync1, sync2, prev;
  logic [W-1:0] eff_en, chg;
  logic         pend, clr;

  assign eff_en = modem_mode ? {{(W-H){modem_irq_en}}, ien_q[H-1:0]} : ien_q;
  assign chg    = (sync2 ^ prev) & ~dir_q & eff_en;
  assign clr    = (wr_en && addr == 2'd0) || (rd_en && addr == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
      ien_q <= '0;
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
      pend  <= 1'b0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
      pend  <= (pend & ~clr) | (|chg);
      if (wr_en) begin
        case (addr)
          2'd0: dir_q <= wdata;
          2'd1: dat_q <= wdata;
          2'd2: ien_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        2'd0: rdata = dir_q;
        2'd1: rdata = sync2;
        2'd2: rdata = ien_q;
        default: rdata = '0;
      endcase
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = dat_q;
  assign irq     = pend;
endmodule

module gpio_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic         wr_en,
  input logic         rd_en,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] chg,
  input logic         irq
);
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> (pin_oe == $past(wdata))); // R1
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 2'd0) |=> $stable(pin_oe)); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 2'd1) |=> $stable(pin_out)); // R3
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|chg)); // R4
  AST_DIR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && !(|chg)) |=> !irq); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd1 && !(|chg)) |=> !irq); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && addr == 2'd0) && !(rd_en && addr == 2'd1)) |=> irq); // R6
  AST_CHANGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg) |=> irq); // R10
endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .pin_out(pin_out), .pin_oe(pin_oe), .chg(chg), .irq(irq)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  logic       clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pin_in = 0;
  logic       wr_en = 0, rd_en = 0, modem_mode = 0, modem_irq_en = 0;
  logic [7:0] rdata, pin_out, pin_oe;
  logic       irq;
  int tests = 0, fails = 0, cycles = 0;

  logic [7:0] m_dir = 0, m_dat = 0, m_ien = 0, m_s1 = 0, m_s2 = 0, m_prev = 0;
  logic       m_pend = 0;

  gpio_port dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return m_dir;
      2'd1: return m_s2;
      2'd2: return m_ien;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] eff_en();
    return modem_mode ? {{4{modem_irq_en}}, m_ien[3:0]} : m_ien;
  endfunction

  // one clock cycle with the given access; model advances from pre-edge values
  task automatic cyc(bit wr, bit rd, logic [1:0] a, logic [7:0] d);
    logic [7:0] c;
    bit clr;
    wr_en = wr; rd_en = rd; addr = a; wdata = d;
    #0.5;
    chk(rd ? "R9 R2 read data" : "R9 idle read data", rdata, rd ? exp_rd(a) : 8'h00);
    c   = (m_s2 ^ m_prev) & ~m_dir & eff_en();
    clr = (wr && a == 2'd0) || (rd && a == 2'd1);
    @(posedge clk);
    m_pend = (m_pend & ~clr) | (|c);
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    if (wr) case (a)
      2'd0: m_dir = d;
      2'd1: m_dat = d;
      2'd2: m_ien = d;
      default: ;
    endcase
    #1;
    wr_en = 0; rd_en = 0;
    chk("R4 R5 R6 R7 R10 irq", {7'd0, irq}, {7'd0, m_pend});
    chk("R1 pin_oe", pin_oe, m_dir);
    chk("R3 pin_out", pin_out, m_dat);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 2'd0, 8'h00);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R8 reset state
    chk("R8 pin_oe", pin_oe, 8'h00);
    chk("R8 pin_out", pin_out, 8'h00);
    chk("R8 irq", {7'd0, irq}, 8'h00);
    cyc(0, 1, 2'd0, 0); cyc(0, 1, 2'd2, 0);
    // R1 R3 direction and stored data
    cyc(1, 0, 2'd1, 8'hA5);
    cyc(1, 0, 2'd0, 8'hF0);
    chk("R3 stored data driven", pin_out & pin_oe, 8'hA0);
    cyc(1, 0, 2'd0, 8'hFF);
    chk("R3 input-time data now driven", pin_out & pin_oe, 8'hA5);
    cyc(0, 1, 2'd3, 0); // R9 address 3 reads zero
    // R2 output pins read actual pad level
    pin_in = 8'h3C; idle(2);
    cyc(0, 1, 2'd1, 0);
    chk("R2 pad level read", m_s2, 8'h3C);
    chk("R4 output pin change no irq", {7'd0, irq}, 8'h00);
    // R4 enabled input change
    cyc(1, 0, 2'd0, 8'h00); cyc(1, 0, 2'd2, 8'h01); idle(3);
    pin_in[0] = ~pin_in[0]; idle(3);
    chk("R4 enabled change raises irq", {7'd0, irq}, 8'h01);
    idle(4);
    chk("R6 sticky irq", {7'd0, irq}, 8'h01);
    cyc(1, 0, 2'd0, 8'h00);
    chk("R5 dir write clears", {7'd0, irq}, 8'h00);
    pin_in[1] = ~pin_in[1]; idle(4);
    chk("R4 disabled pin no irq", {7'd0, irq}, 8'h00);
    // R10 change coincides with direction write, then with read
    pin_in[0] = ~pin_in[0]; idle(4);
    pin_in[0] = ~pin_in[0]; idle(2); cyc(1, 0, 2'd0, 8'h00);
    chk("R10 change wins over dir write", {7'd0, irq}, 8'h01);
    pin_in[0] = ~pin_in[0]; idle(2); cyc(0, 1, 2'd1, 0);
    chk("R10 change wins over read", {7'd0, irq}, 8'h01);
    cyc(0, 1, 2'd1, 0);
    chk("R6 read clears", {7'd0, irq}, 8'h00);
    // R7 modem mode
    cyc(1, 0, 2'd2, 8'hF0); modem_mode = 1; modem_irq_en = 0; idle(3);
    pin_in[6] = ~pin_in[6]; idle(4);
    chk("R7 per-pin enable ignored", {7'd0, irq}, 8'h00);
    modem_irq_en = 1; pin_in[7] = ~pin_in[7]; idle(4);
    chk("R7 shared enable raises irq", {7'd0, irq}, 8'h01);
    cyc(0, 1, 2'd1, 0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 3) pin_in = pin_in ^ 8'($urandom);
      if (r == 9) begin modem_mode = 1'($urandom); modem_irq_en = 1'($urandom); end
      case ($urandom_range(0, 3))
        0: cyc(1, 0, 2'($urandom), 8'($urandom));
        1: cyc(0, 1, 2'($urandom), 0);
        default: cyc(0, 0, 2'd0, 0);
      endcase
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule